// File: doc/BRIEF.md
# Microprogrammed Fetch and Dispatch Control Unit

This block is the control unit and a minimal datapath for a small 16-bit load/store processor. A micro-program counter addresses a control store. Each control word gives the load enables of the datapath registers and selects which single source drives the shared internal bus. It also holds the next micro-address and the rule for choosing the next state. The unit fetches an instruction, decodes it, and jumps to a microroutine picked by the opcode. It implements a conditional branch and a word load with a scaled, signed offset.

The datapath holds a program counter, a memory address register, a memory data register, an instruction register, eight 16-bit general registers and one-hot condition codes. Memory is external and word-addressed. The unit raises a read strobe with a byte address and waits until memory signals ready. For observation, the top exposes the program counter, the condition codes, the latched branch-enable bit, the micro-PC and one general register chosen by a select input.

Top module: `useq_core`

## Requirements
- R1: After reset, PC is 0, the micro-PC is at the fetch micro-address 18, the condition codes `{N,Z,P}` read 3'b010 and all eight general registers read 0.
- R2: In the fetch micro-state (18), MAR takes the value of PC and PC is incremented by 2, both in the same cycle.
- R3: Each memory read micro-state (33 for instructions, 25 for load data) holds until `mem_ready` is high, so a read with L wait cycles takes L+1 cycles. One load-word instruction takes 7+2L cycles from fetch to fetch, and a branch or undefined instruction takes 5+L.
- R4: The instruction register is loaded from MDR. The decode micro-state (32) then jumps to the micro-address equal to IR[15:12].
- R5: In decode, branch-enable is latched as `(IR[11]&N)|(IR[10]&Z)|(IR[9]&P)` and keeps its value until the next decode.
- R6: Opcode 4'b0000 is a branch. When branch-enable is set, PC (already incremented) gets PC + (sign-extended IR[8:0] shifted left by 1). Otherwise PC is unchanged.
- R7: Opcode 4'b0110 is a word load. The destination is IR[11:9], the base is IR[8:6], and the address is base + (sign-extended IR[5:0] shifted left by 1). The word read at that address is written to the destination register.
- R8: A load sets the condition codes one-hot from the written word: N (3'b100) when bit 15 is set, Z (3'b010) when the word is zero, and P (3'b001) otherwise.
- R9: Every opcode other than 4'b0000 and 4'b0110 returns to fetch and leaves the general registers, the condition codes and PC unchanged, apart from the fetch increment.
- R10: No more than one source drives the shared bus in any cycle.
- R11: The last micro-state of every instruction's routine leads back to the fetch micro-address 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Byte address of the read (MAR) |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory has completed the read |
| dbg_sel | input | 3 | Selects the general register shown on `dbg_data` |
| dbg_data | output | 16 | Contents of the selected general register |
| pc | output | 16 | Program counter |
| cc | output | 3 | Condition codes `{N,Z,P}` |
| ben | output | 1 | Latched branch-enable bit |
| upc | output | 6 | Current micro-PC |

## Verification
The assertions assume that memory raises `mem_ready` only while `mem_rd` is high, and that `mem_rdata` holds the addressed word in that cycle. The wait-hold property and the load results rest on this. The bench memory model derives ready from the strobe and a programmable latency counter, so ready never appears without a request. Its data is a combinational lookup at the current MAR. The programs start from reset with known register contents. They use latencies of zero to two cycles, so both the single-cycle and the stalled paths through the read states are covered.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UPC_W = 6;

  localparam logic [UPC_W-1:0] UA_FETCH0  = 6'd18;
  localparam logic [UPC_W-1:0] UA_FETCH1  = 6'd33;
  localparam logic [UPC_W-1:0] UA_FETCH2  = 6'd35;
  localparam logic [UPC_W-1:0] UA_DECODE  = 6'd32;
  localparam logic [UPC_W-1:0] UA_BR      = 6'd0;
  localparam logic [UPC_W-1:0] UA_LDW     = 6'd6;
  localparam logic [UPC_W-1:0] UA_LDW_RD  = 6'd25;
  localparam logic [UPC_W-1:0] UA_LDW_WB  = 6'd27;

  typedef enum logic [1:0] {
    NX_JUMP = 2'd0,
    NX_WAIT = 2'd1,
    NX_DISP = 2'd2
  } nxt_e;

  // datapath controls carried by one control word
  typedef struct packed {
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic ld_pc;
    logic ld_ben;
    logic ld_reg;
    logic ld_cc;
    logic g_pc;     // PC drives bus
    logic g_mdr;    // MDR drives bus
    logic g_adr;    // address adder drives bus
    logic pc_inc;   // PC source: PC+2 instead of bus
    logic br_cond;  // PC load qualified by branch-enable
    logic a1_pc;    // adder base: PC instead of register
    logic a2_off9;  // adder offset: 9-bit field instead of 6-bit
  } ctl_t;

  typedef struct packed {
    nxt_e             mode;
    logic [UPC_W-1:0] j;
    logic             mem_rd;
    ctl_t             ctl;
  } uword_t;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [UPC_W-1:0] upc,
  output uword_t           uw
);

  always_comb begin
    uw      = '0;
    uw.mode = NX_JUMP;
    uw.j    = UA_FETCH0;          // unlisted words return to fetch
    case (upc)
      UA_FETCH0: begin
        uw.j          = UA_FETCH1;
        uw.ctl.g_pc   = 1'b1;
        uw.ctl.ld_mar = 1'b1;
        uw.ctl.ld_pc  = 1'b1;
        uw.ctl.pc_inc = 1'b1;
      end
      UA_FETCH1: begin
        uw.mode       = NX_WAIT;
        uw.j          = UA_FETCH2;
        uw.mem_rd     = 1'b1;
        uw.ctl.ld_mdr = 1'b1;
      end
      UA_FETCH2: begin
        uw.j          = UA_DECODE;
        uw.ctl.g_mdr  = 1'b1;
        uw.ctl.ld_ir  = 1'b1;
      end
      UA_DECODE: begin
        uw.mode       = NX_DISP;
        uw.ctl.ld_ben = 1'b1;
      end
      UA_BR: begin
        uw.ctl.a1_pc   = 1'b1;
        uw.ctl.a2_off9 = 1'b1;
        uw.ctl.g_adr   = 1'b1;
        uw.ctl.ld_pc   = 1'b1;
        uw.ctl.br_cond = 1'b1;
      end
      UA_LDW: begin
        uw.j          = UA_LDW_RD;
        uw.ctl.g_adr  = 1'b1;
        uw.ctl.ld_mar = 1'b1;
      end
      UA_LDW_RD: begin
        uw.mode       = NX_WAIT;
        uw.j          = UA_LDW_WB;
        uw.mem_rd     = 1'b1;
        uw.ctl.ld_mdr = 1'b1;
      end
      UA_LDW_WB: begin
        uw.ctl.g_mdr  = 1'b1;
        uw.ctl.ld_reg = 1'b1;
        uw.ctl.ld_cc  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  nxt_e             mode,
  input  logic [UPC_W-1:0] jaddr,
  input  logic             mem_ready,
  input  logic [3:0]       opcode,
  output logic [UPC_W-1:0] upc
);

  logic [UPC_W-1:0] upc_d;

  always_comb begin
    case (mode)
      NX_WAIT: upc_d = mem_ready ? jaddr : upc;
      NX_DISP: upc_d = {{(UPC_W-4){1'b0}}, opcode};
      default: upc_d = jaddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= UA_FETCH0;
    else        upc <= upc_d;
  end

endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RSEL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  input  logic [RSEL-1:0] dbg_sel,
  output logic [DW-1:0]   mar,
  output logic [DW-1:0]   ir,
  output logic [DW-1:0]   pc,
  output logic [2:0]      cc,
  output logic            ben,
  output logic [DW-1:0]   dbg_data
);

  localparam int NREG = 1 << RSEL;

  logic [DW-1:0] mdr;
  logic [DW-1:0] rf [NREG];

  logic [RSEL-1:0] dr, sr1;
  logic [DW-1:0]   base, off6, off9, a1, a2, adr, bus, pc_d;
  logic [2:0]      cc_d;
  logic            ben_d, pc_en, mdr_en;

  assign dr   = ir[11:9];
  assign sr1  = ir[8:6];
  assign base = rf[sr1];
  assign off6 = {{(DW-7){ir[5]}}, ir[5:0], 1'b0};
  assign off9 = {{(DW-10){ir[8]}}, ir[8:0], 1'b0};

  always_comb begin
    a1  = ctl.a1_pc   ? pc   : base;
    a2  = ctl.a2_off9 ? off9 : off6;
    adr = a1 + a2;
    // wired bus: each gate stands for one tri-state driver
    bus = ({DW{ctl.g_pc}}  & pc)  |
          ({DW{ctl.g_mdr}} & mdr) |
          ({DW{ctl.g_adr}} & adr);
    pc_d    = ctl.pc_inc ? pc + DW'(2) : bus;
    pc_en   = ctl.ld_pc & (~ctl.br_cond | ben);
    mdr_en  = ctl.ld_mdr & mem_ready;
    cc_d[2] = bus[DW-1];
    cc_d[1] = (bus == '0);
    cc_d[0] = ~bus[DW-1] & (bus != '0);
    ben_d   = |(ir[11:9] & cc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      cc  <= 3'b010;
      ben <= 1'b0;
    end else begin
      if (pc_en)      pc  <= pc_d;
      if (ctl.ld_mar) mar <= bus;
      if (mdr_en)     mdr <= mem_rdata;
      if (ctl.ld_ir)  ir  <= bus;
      if (ctl.ld_cc)  cc  <= cc_d;
      if (ctl.ld_ben) ben <= ben_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rf[g] <= '0;
      else if (ctl.ld_reg && dr == RSEL'(g))   rf[g] <= bus;
    end
  end

  assign dbg_data = rf[dbg_sel];

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             mem_rd,
  output logic [DW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  input  logic [2:0]       dbg_sel,
  output logic [DW-1:0]    dbg_data,
  output logic [DW-1:0]    pc,
  output logic [2:0]       cc,
  output logic             ben,
  output logic [UPC_W-1:0] upc
);

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  uword_t        uw;
  logic [DW-1:0] ir_w;
  logic [2:0]    bus_gates;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  useq_rom u_rom (
    .upc (upc),
    .uw  (uw)
  );

  useq_next u_next (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (uw.mode),
    .jaddr     (uw.j),
    .mem_ready (mem_ready),
    .opcode    (ir_w[15:12]),
    .upc       (upc)
  );

  useq_dp #(.DW(DW), .RSEL(3)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl       (uw.ctl),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .dbg_sel   (dbg_sel),
    .mar       (mem_addr),
    .ir        (ir_w),
    .pc        (pc),
    .cc        (cc),
    .ben       (ben),
    .dbg_data  (dbg_data)
  );

  assign mem_rd    = uw.mem_rd;
  assign bus_gates = {uw.ctl.g_pc, uw.ctl.g_mdr, uw.ctl.g_adr};

endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UPC_W-1:0] upc,
  input logic [DW-1:0]    pc,
  input logic [DW-1:0]    mar,
  input logic [6:0]       ir_hi,   // IR[15:9]
  input logic [2:0]       cc,
  input logic             ben,
  input logic             mem_rd,
  input logic             mem_ready,
  input logic [2:0]       gates
);

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upc == UA_FETCH0 |=> (pc == $past(pc) + DW'(2)) && (mar == $past(pc)));

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_ready |=> $stable(upc));

  assert_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upc == UA_DECODE |=> upc == {{(UPC_W-4){1'b0}}, $past(ir_hi[6:3])});

  assert_ben_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upc == UA_DECODE |=> ben == |($past(ir_hi[2:0]) & $past(cc)));

  assert_cc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cc));

  assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gates));

  assert_routine_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upc == UA_LDW_WB |=> upc == UA_FETCH0);

endmodule

bind useq_core useq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .upc       (upc),
  .pc        (pc),
  .mar       (mem_addr),
  .ir_hi     (ir_w[15:9]),
  .cc        (cc),
  .ben       (ben),
  .mem_rd    (mem_rd),
  .mem_ready (mem_ready),
  .gates     (bus_gates)
);

// File: tb/tb_useq_core.sv
module tb_useq_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_rd;
  logic [15:0] mem_addr, mem_rdata;
  logic        mem_ready;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_data, pc;
  logic [2:0]  cc;
  logic        ben;
  logic [5:0]  upc;

  logic [15:0] mem [256];
  int lat = 0;
  int rd_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  useq_core dut (
    .clk (clk), .rst_n (rst_n), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .mem_ready (mem_ready), .dbg_sel (dbg_sel),
    .dbg_data (dbg_data), .pc (pc), .cc (cc), .ben (ben), .upc (upc)
  );

  // memory model: ready after lat stalled cycles of an active strobe
  always @(posedge clk) begin
    if (mem_rd && !mem_ready) rd_cnt <= rd_cnt + 1;
    else                      rd_cnt <= 0;
  end
  assign mem_ready = mem_rd && (rd_cnt >= lat);
  assign mem_rdata = mem[mem_addr[8:1]];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_reg(input int i, output logic [15:0] v);
    dbg_sel = 3'(i);
    #1;
    v = dbg_data;
  endtask

  // runs one instruction from fetch back to fetch, returns its cycle count
  task automatic run_instr(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (upc != 6'd18 && cyc < 500);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    clear_mem();
    mem[0] = 16'hD000;
    do_reset();
    chk("R1 pc", pc, 16'h0000);
    chk("R1 upc", 16'(upc), 16'd18);
    chk("R1 cc", 16'(cc), 16'h0002);
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      chk($sformatf("R1 reg%0d", i), v, 16'h0000);
    end
  endtask

  task automatic t_ldw_basic();
    logic [15:0] v;
    int c;
    clear_mem();
    lat = 0;
    mem[0] = 16'h6204;      // load R1 from R0 + 4*2
    mem[4] = 16'h8001;
    do_reset();
    run_instr(c);
    chk("R3 R11 ldw cycles lat0", 16'(c), 16'd7);
    read_reg(1, v);
    chk("R4 R7 R10 ldw value", v, 16'h8001);
    chk("R8 cc negative", 16'(cc), 16'h0004);
    chk("R2 pc after one fetch", pc, 16'h0002);
  endtask

  task automatic t_ldw_chain();
    logic [15:0] v;
    int c;
    clear_mem();
    lat = 2;
    mem[0]  = 16'h6606;     // R3 <- word at 12
    mem[1]  = 16'h68FE;     // R4 <- word at R3 - 4
    mem[2]  = 16'h6A07;     // R5 <- word at 14
    mem[6]  = 16'h0040;
    mem[7]  = 16'h0000;
    mem[30] = 16'h1234;
    do_reset();
    run_instr(c);
    chk("R3 ldw cycles lat2", 16'(c), 16'd11);
    read_reg(3, v);
    chk("R7 base R0 load", v, 16'h0040);
    chk("R8 cc positive", 16'(cc), 16'h0001);
    run_instr(c);
    read_reg(4, v);
    chk("R7 negative offset load", v, 16'h1234);
    run_instr(c);
    read_reg(5, v);
    chk("R7 zero word load", v, 16'h0000);
    chk("R8 cc zero", 16'(cc), 16'h0002);
    chk("R2 pc after three", pc, 16'h0006);
  endtask

  task automatic t_undef();
    logic [15:0] v;
    int c;
    clear_mem();
    lat = 1;
    mem[0] = 16'h6204;
    mem[1] = 16'hDFFF;      // undefined opcode 1101, all fields ones
    mem[4] = 16'h8001;
    do_reset();
    run_instr(c);
    run_instr(c);
    chk("R3 R9 undefined cycles lat1", 16'(c), 16'd6);
    read_reg(1, v);
    chk("R9 R1 kept", v, 16'h8001);
    read_reg(7, v);
    chk("R9 R7 untouched", v, 16'h0000);
    chk("R9 cc kept", 16'(cc), 16'h0004);
    chk("R9 pc fetch only", pc, 16'h0004);
  endtask

  task automatic t_branch();
    int c;
    clear_mem();
    lat = 0;
    mem[0] = 16'h0403;      // branch on Z, +3 words
    do_reset();
    run_instr(c);
    chk("R3 branch cycles", 16'(c), 16'd5);
    chk("R5 ben taken", 16'(ben), 16'h0001);
    chk("R6 taken target", pc, 16'h0008);

    clear_mem();
    mem[0] = 16'h0803;      // branch on N while Z
    do_reset();
    run_instr(c);
    chk("R5 ben not taken", 16'(ben), 16'h0000);
    chk("R6 not taken pc", pc, 16'h0002);

    clear_mem();
    mem[0] = 16'h6606;      // sets P
    mem[1] = 16'h03FE;      // branch on P, -2 words
    mem[6] = 16'h0040;
    do_reset();
    run_instr(c);
    run_instr(c);
    chk("R5 ben from P", 16'(ben), 16'h0001);
    chk("R6 backward target", pc, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    dbg_sel = 3'd0;
    t_reset();
    t_ldw_basic();
    t_ldw_chain();
    t_undef();
    t_branch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule